// File: doc/BRIEF.md
# Interrupt Redirection Table with End-of-Interrupt Matching

This block holds a small table of redirection entries, one per interrupt input. Each entry carries an 8-bit vector, a trigger-mode bit, a mask bit and a read-only "delivery outstanding" flag (`rirr`). Software reaches the table indirectly. It writes an entry selector into the index register and then reads or writes the selected entry through the 32-bit data register. A separate write-only end-of-interrupt (EOI) register takes a vector number.

Pending entries raise a valid/ready delivery request that carries the vector. The lowest-numbered pending entry is served first. A level-triggered entry sets `rirr` when its request is accepted and stays silent until an EOI names its vector. The EOI vector is compared against every entry in the same cycle. Every level entry that matches has `rirr` cleared, even where the clear comes too early for one of them. A level input that is still asserted therefore raises its request again, so entries that share a vector lose nothing. Edge-triggered entries deliver once per rising edge and take no part in EOI handling.

Top module: `irq_redir_unit`

## Requirements
- R1: After reset, the index register reads 0, the data register reads 0 at index 0, and every entry reads 0x00010000 (masked, edge, vector 0, `rirr` 0). `out_valid` is 0.
- R2: The index register sits at offset 0x00 and uses bits 7:0. Entry n is selected by index 0x10+2n. Through offset 0x10 its word is vector in bits 7:0, `rirr` in bit 14, level mode in bit 15 (1 = level, 0 = edge) and mask in bit 16. All other bits read 0. A read returns data on `bus_rdata` in the cycle after the access.
- R3: The data register is accessed only as a full word. A write with `bus_be` other than 4'hF changes nothing, and a read with `bus_be` other than 4'hF returns 0.
- R4: A write to offset 0x40 is an EOI. Only bits 7:0 of the written value are used, and bits 31:8 are ignored. A read of offset 0x40 returns 0.
- R5: An EOI clears `rirr` on every level entry whose vector equals the EOI vector, all in the same cycle. Entries with another vector keep `rirr`.
- R6: When a level entry's request is accepted, its `rirr` becomes 1. While `rirr` is 1, that entry makes no request.
- R7: A level entry whose input is still high when its `rirr` is cleared requests delivery again.
- R8: An unmasked edge entry delivers exactly once per rising edge of its input. It never sets `rirr`, and an EOI has no effect on it.
- R9: A masked entry never requests. Edges that arrive while an entry is masked are dropped.
- R10: Software writes to bit 14 (`rirr`) of an entry are ignored.
- R11: When several entries are pending, the lowest-numbered entry is offered first, and one entry is served per accepted handshake.
- R12: Reads of unimplemented offsets, odd indices and indices past the last entry return 0. Writes to them change nothing.
- R13: A request appears on `out_valid`/`out_vector` on the first clock edge after the input change that causes it, and also on the first edge after an EOI that re-arms a still-high level input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| irq_in | input | NUM_ENTRIES | Interrupt inputs, one per entry |
| out_valid | output | 1 | Delivery request present |
| out_ready | input | 1 | Delivery request accepted when high with `out_valid` |
| out_vector | output | 8 | Vector of the offered entry |

## Verification
Each result has a fixed latency. Register read data appears in the cycle after the access. A new request or a re-arm after an EOI shows on the outputs one edge after its cause. An accepted handshake removes the entry's request at that same edge. The bench drives every input at the falling edge and samples at the next falling edge, so each check falls exactly in the cycle where the result is due. A scoreboard queue holds the vectors expected in delivery order. The monitor pops one entry for every handshake it sees, so a surplus, missing or reordered delivery is reported. Queue drain checks after every stimulus group confirm that nothing extra was delivered while the inputs were held.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;

  localparam logic [7:0] OFS_INDEX = 8'h00;
  localparam logic [7:0] OFS_DATA  = 8'h10;
  localparam logic [7:0] OFS_EOI   = 8'h40;

  localparam int BIT_RIRR  = 14;
  localparam int BIT_LEVEL = 15;
  localparam int BIT_MASK  = 16;

  typedef struct packed {
    logic             mask;
    logic             level;
    logic [VEC_W-1:0] vector;
  } redir_cfg_t;

  localparam redir_cfg_t CFG_RESET = '{mask: 1'b1, level: 1'b0, vector: '0};

  // Assemble the software-visible word of one entry.
  function automatic logic [DATA_W-1:0] pack_entry(redir_cfg_t c, logic rirr);
    logic [DATA_W-1:0] w;
    w            = '0;
    w[VEC_W-1:0] = c.vector;
    w[BIT_RIRR]  = rirr;
    w[BIT_LEVEL] = c.level;
    w[BIT_MASK]  = c.mask;
    return w;
  endfunction

  // Extract the writable fields; bit 14 is deliberately not taken.
  function automatic redir_cfg_t unpack_cfg(logic [DATA_W-1:0] w);
    redir_cfg_t c;
    c.vector = w[VEC_W-1:0];
    c.level  = w[BIT_LEVEL];
    c.mask   = w[BIT_MASK];
    return c;
  endfunction

  // End-of-interrupt vector comparison: only the low byte counts.
  function automatic logic eoi_match(logic [DATA_W-1:0] wdata, logic [VEC_W-1:0] vec);
    return wdata[VEC_W-1:0] == vec;
  endfunction

  // Isolate the lowest set bit of a request vector.
  function automatic logic [63:0] lowest_bit(logic [63:0] r);
    return r & (~r + 64'd1);
  endfunction

endpackage

// File: rtl/irq_regif.sv
module irq_regif
  import irq_redir_pkg::*;
#(
  parameter int         N        = 8,
  parameter logic [7:0] IDX_BASE = 8'h10,
  localparam int        ENT_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [7:0]                 bus_addr,
  input  logic [3:0]                 bus_be,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [N-1:0][DATA_W-1:0]   entry_rdata,
  output logic [N-1:0]               cfg_we,
  output logic [DATA_W-1:0]          cfg_wdata,
  output logic                       eoi_we,
  output logic [VEC_W-1:0]           eoi_vec
);

  logic [7:0]       index_q;
  logic [7:0]       idx_off;
  logic             sel_valid;
  logic [ENT_W-1:0] sel_ent;
  logic             acc_index, acc_data, acc_eoi, acc_other;
  logic [DATA_W-1:0] rd_mux;

  // Offset decode; the data register needs all four byte lanes.
  assign acc_index = bus_en && (bus_addr == OFS_INDEX);
  assign acc_data  = bus_en && (bus_addr == OFS_DATA) && (bus_be == 4'hF);
  assign acc_eoi   = bus_en && (bus_addr == OFS_EOI);
  assign acc_other = bus_en && (bus_addr != OFS_INDEX) && (bus_addr != OFS_DATA)
                     && (bus_addr != OFS_EOI);

  // Index to entry translation: even indices from IDX_BASE upward.
  assign idx_off   = index_q - IDX_BASE;
  assign sel_valid = (index_q >= IDX_BASE) && !idx_off[0]
                     && ({1'b0, idx_off[7:1]} < 8'(N));
  assign sel_ent   = idx_off[ENT_W:1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      index_q <= '0;
    else if (acc_index && bus_we && bus_be[0])
      index_q <= bus_wdata[7:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_we
    assign cfg_we[i] = acc_data && bus_we && sel_valid && (sel_ent == ENT_W'(i));
  end

  assign cfg_wdata = bus_wdata;
  assign eoi_we    = acc_eoi && bus_we;
  assign eoi_vec   = bus_wdata[VEC_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (acc_index)
      rd_mux = {24'd0, index_q};
    else if (acc_data && sel_valid)
      rd_mux = entry_rdata[sel_ent];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_en && !bus_we)
      bus_rdata <= rd_mux;
  end

  p_eoi_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_eoi && !bus_we) |=> (bus_rdata == '0));

  p_partial_data_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && (bus_addr == OFS_DATA) && (bus_be != 4'hF)) |-> (cfg_we == '0));

  p_stray_offset_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_other && !bus_we) |=> (bus_rdata == '0));

endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_redir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              eoi_we,
  input  logic [VEC_W-1:0]  eoi_vec,
  input  logic              grant,
  output logic              req,
  output logic [VEC_W-1:0]  vector,
  output logic [DATA_W-1:0] rdata
);

  redir_cfg_t cfg_q;
  logic       irq_s;
  logic       rise;
  logic       edge_pend_q;
  logic       rirr_q;
  logic       eoi_hit;
  logic       level_next;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= CFG_RESET;
    else if (cfg_we)
      cfg_q <= unpack_cfg(cfg_wdata);
  end

  // Input sampling register, also the reference for edge detection.
  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_s <= 1'b0;
    else
      irq_s <= irq_in;
  end

  assign rise       = irq_in && !irq_s;
  assign eoi_hit    = eoi_we && cfg_q.level && eoi_match({24'd0, eoi_vec}, cfg_q.vector);
  assign level_next = cfg_we ? cfg_wdata[BIT_LEVEL] : cfg_q.level;

  // Edge latch: dropped while masked or in level mode.
  always_ff @(posedge clk) begin
    if (!rst_n)
      edge_pend_q <= 1'b0;
    else if (cfg_q.mask || cfg_q.level)
      edge_pend_q <= 1'b0;
    else
      edge_pend_q <= rise || (edge_pend_q && !grant);
  end

  // Delivery-outstanding flag for level entries only.
  always_ff @(posedge clk) begin
    if (!rst_n)
      rirr_q <= 1'b0;
    else if (!level_next)
      rirr_q <= 1'b0;
    else if (grant)
      rirr_q <= 1'b1;
    else if (eoi_hit)
      rirr_q <= 1'b0;
  end

  assign req    = !cfg_q.mask && (cfg_q.level ? (irq_s && !rirr_q) : edge_pend_q);
  assign vector = cfg_q.vector;
  assign rdata  = pack_entry(cfg_q, rirr_q);

  p_edge_no_rirr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.level |-> !rirr_q);

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.mask |-> !req);

  p_rirr_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_q |-> !req);

  p_grant_sets_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && level_next) |=> rirr_q);

  p_eoi_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !grant) |=> !rirr_q);

  p_rirr_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && level_next && cfg_q.level && !grant && !eoi_hit) |=> $stable(rirr_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_redir_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            req,
  input  logic [N-1:0][VEC_W-1:0] vectors,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [VEC_W-1:0]        out_vector,
  output logic [N-1:0]            grant
);

  logic [N-1:0] pick;

  assign pick      = N'(lowest_bit(64'(req)));
  assign out_valid = |req;
  assign grant     = out_ready ? pick : '0;

  always_comb begin
    out_vector = '0;
    for (int i = 0; i < N; i++)
      if (pick[i]) out_vector = out_vector | vectors[i];
  end

  p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - 1'b1)) == '0));

  p_grant_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0));

endmodule

// File: rtl/irq_redir_unit.sv
module irq_redir_unit
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENTRIES = 8,
  parameter logic [7:0] IDX_BASE    = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [7:0]             bus_addr,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_ENTRIES-1:0] irq_in,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_vector
);

  logic [NUM_ENTRIES-1:0][DATA_W-1:0] entry_rdata;
  logic [NUM_ENTRIES-1:0][VEC_W-1:0]  entry_vec;
  logic [NUM_ENTRIES-1:0]             cfg_we;
  logic [NUM_ENTRIES-1:0]             req;
  logic [NUM_ENTRIES-1:0]             grant;
  logic [DATA_W-1:0]                  cfg_wdata;
  logic                               eoi_we;
  logic [VEC_W-1:0]                   eoi_vec;

  irq_regif #(.N(NUM_ENTRIES), .IDX_BASE(IDX_BASE)) u_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .entry_rdata (entry_rdata),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .eoi_we      (eoi_we),
    .eoi_vec     (eoi_vec)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    irq_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in[i]),
      .cfg_we    (cfg_we[i]),
      .cfg_wdata (cfg_wdata),
      .eoi_we    (eoi_we),
      .eoi_vec   (eoi_vec),
      .grant     (grant[i]),
      .req       (req[i]),
      .vector    (entry_vec[i]),
      .rdata     (entry_rdata[i])
    );
  end

  irq_arbiter #(.N(NUM_ENTRIES)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .vectors    (entry_vec),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_vector (out_vector),
    .grant      (grant)
  );

endmodule

// File: tb/irq_redir_unit_bench.sv
`timescale 1ns/1ps
module irq_redir_unit_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq_in;
  logic        out_valid, out_ready;
  logic [7:0]  out_vector;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  irq_redir_unit #(.NUM_ENTRIES(N)) u_irq_redir_unit (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_vector(out_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_word(logic [7:0] v, bit lvl, bit msk, bit rirr);
    logic [31:0] w;
    w = {24'd0, v};
    if (rirr) w = w | 32'h0000_4000;
    if (lvl)  w = w | 32'h0000_8000;
    if (msk)  w = w | 32'h0001_0000;
    return w;
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_entry(input int n, input logic [31:0] w);
    bus_write(8'h00, 4'hF, 32'(8'h10 + 8'(2 * n)));
    bus_write(8'h10, 4'hF, w);
  endtask

  task automatic check_entry(input int n, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_write(8'h00, 4'hF, 32'(8'h10 + 8'(2 * n)));
    bus_read(8'h10, 4'hF, d);
    chk(d === exp, tag, d, exp);
  endtask

  task automatic expect_vec(input logic [7:0] v, input string tag);
    exp_t e;
    e.vec = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
  endtask

  // Monitor: a handshake completes at the edge after this sample.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && out_ready === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R6/R9 unexpected delivery", {24'd0, out_vector}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_vector === e.vec, e.tag, {24'd0, out_vector}, {24'd0, e.vec});
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; irq_in = '0; out_ready = 1'b0;
    wait_cycles(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(out_valid === 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    bus_read(8'h00, 4'hF, d);
    chk(d === 32'd0, "R1 index reset", d, 32'd0);
    bus_read(8'h10, 4'hF, d);
    chk(d === 32'd0, "R1 data reset at index 0", d, 32'd0);
    check_entry(0, 32'h0001_0000, "R1 entry 0 reset word");
    check_entry(N - 1, 32'h0001_0000, "R1 last entry reset word");

    // R2 indirect write and read back
    set_entry(2, ent_word(8'h41, 0, 0, 0));
    check_entry(2, 32'h0000_0041, "R2 entry 2 readback");
    bus_read(8'h00, 4'hF, d);
    chk(d === 32'h14, "R2 index readback", d, 32'h14);

    // R3 partial access to the data register
    bus_write(8'h10, 4'h3, 32'h0001_80AA);
    bus_read(8'h10, 4'hF, d);
    chk(d === 32'h41, "R3 partial write ignored", d, 32'h41);
    bus_read(8'h10, 4'h1, d);
    chk(d === 32'd0, "R3 partial read zero", d, 32'd0);

    // R12 unimplemented offsets and indices
    bus_read(8'h20, 4'hF, d);
    chk(d === 32'd0, "R12 stray offset read", d, 32'd0);
    bus_write(8'h00, 4'hF, 32'h15);
    bus_write(8'h10, 4'hF, 32'h0000_8077);
    bus_read(8'h10, 4'hF, d);
    chk(d === 32'd0, "R12 odd index read", d, 32'd0);
    bus_write(8'h00, 4'hF, 32'(8'h10 + 8'(2 * N)));
    bus_read(8'h10, 4'hF, d);
    chk(d === 32'd0, "R12 index past table", d, 32'd0);
    check_entry(2, 32'h0000_0041, "R12 entry 2 untouched by odd index write");

    // R8 edge entry: one delivery per rising edge, EOI no effect
    out_ready = 1'b1;
    expect_vec(8'h41, "R8 first edge");
    irq_in[2] = 1'b1;
    wait_cycles(6);
    drained("R8 single delivery while high");
    irq_in[2] = 1'b0;
    wait_cycles(2);
    expect_vec(8'h41, "R8 second edge");
    irq_in[2] = 1'b1;
    wait_cycles(4);
    drained("R8 second edge delivered");
    bus_write(8'h40, 4'hF, 32'h41);
    wait_cycles(4);
    drained("R8 EOI no re-delivery");
    check_entry(2, 32'h0000_0041, "R8 edge rirr stays 0");
    irq_in[2] = 1'b0;

    // R11/R13 level entries sharing a vector, ready held low
    out_ready = 1'b0;
    set_entry(3, ent_word(8'h60, 1, 0, 0));
    set_entry(5, ent_word(8'h60, 1, 0, 0));
    set_entry(6, ent_word(8'h61, 1, 0, 0));
    @(negedge clk);
    irq_in[3] = 1'b1; irq_in[5] = 1'b1; irq_in[6] = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b1, "R13 valid one edge after input", {31'd0, out_valid}, 32'd1);
    chk(out_vector === 8'h60, "R11 lowest entry offered", {24'd0, out_vector}, 32'h60);
    expect_vec(8'h60, "R11 entry 3 first");
    expect_vec(8'h60, "R11 entry 5 second");
    expect_vec(8'h61, "R11 entry 6 third");
    out_ready = 1'b1;
    wait_cycles(10);
    drained("R6 no repeat while rirr set");
    check_entry(3, ent_word(8'h60, 1, 0, 1), "R6 rirr set on entry 3");

    // R5/R7 EOI with junk upper bits clears both sharers, re-issue
    expect_vec(8'h60, "R7 entry 3 re-issued");
    expect_vec(8'h60, "R7 entry 5 re-issued");
    bus_write(8'h40, 4'hF, 32'hABCD_EF60);
    wait_cycles(6);
    drained("R5 both sharers re-issued");
    check_entry(6, ent_word(8'h61, 1, 0, 1), "R5 other vector keeps rirr");

    // R13 re-arm timing: EOI edge then valid at next sample
    out_ready = 1'b0;
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h40; bus_be = 4'hF; bus_wdata = 32'h61;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    chk(out_valid === 1'b1 && out_vector === 8'h61, "R13 re-arm one edge after EOI",
        {23'd0, out_valid, out_vector}, 32'h161);
    expect_vec(8'h61, "R7 entry 6 re-issued");
    out_ready = 1'b1;
    wait_cycles(3);
    drained("R7 entry 6 delivered");

    // R4 upper bits ignored, EOI reads zero
    bus_write(8'h40, 4'hF, 32'h0000_6100);
    check_entry(6, ent_word(8'h61, 1, 0, 1), "R4 bits 31:8 ignored");
    bus_read(8'h40, 4'hF, d);
    chk(d === 32'd0, "R4 EOI reads zero", d, 32'd0);

    // R5 clear with inputs low: no delivery
    irq_in[3] = 1'b0; irq_in[5] = 1'b0;
    wait_cycles(2);
    bus_write(8'h40, 4'hF, 32'h60);
    wait_cycles(3);
    drained("R5 cleared without re-issue");
    check_entry(3, ent_word(8'h60, 1, 0, 0), "R5 entry 3 rirr cleared");
    check_entry(5, ent_word(8'h60, 1, 0, 0), "R5 entry 5 rirr cleared");

    // R10 rirr not writable
    set_entry(6, ent_word(8'h61, 1, 0, 0));
    check_entry(6, ent_word(8'h61, 1, 0, 1), "R10 write of 0 ignored");
    set_entry(3, ent_word(8'h60, 1, 0, 1));
    check_entry(3, ent_word(8'h60, 1, 0, 0), "R10 write of 1 ignored");

    // R9 masking
    set_entry(6, ent_word(8'h61, 1, 1, 0));
    bus_write(8'h40, 4'hF, 32'h61);
    wait_cycles(4);
    drained("R9 masked level silent");
    check_entry(6, ent_word(8'h61, 1, 1, 0), "R9 masked entry word");
    set_entry(2, ent_word(8'h41, 0, 1, 0));
    irq_in[2] = 1'b1;
    wait_cycles(3);
    irq_in[2] = 1'b0;
    set_entry(2, ent_word(8'h41, 0, 0, 0));
    wait_cycles(3);
    drained("R9 edge while masked dropped");
    expect_vec(8'h61, "R9 unmask delivers held level");
    set_entry(6, ent_word(8'h61, 1, 0, 0));
    wait_cycles(3);
    drained("R9 unmask delivered");

    // R11 edge ordering across three entries
    set_entry(0, ent_word(8'h20, 0, 0, 0));
    set_entry(1, ent_word(8'h21, 0, 0, 0));
    out_ready = 1'b0;
    @(negedge clk);
    irq_in[0] = 1'b1; irq_in[1] = 1'b1; irq_in[2] = 1'b1;
    @(negedge clk);
    chk(out_vector === 8'h20, "R11 entry 0 offered first", {24'd0, out_vector}, 32'h20);
    expect_vec(8'h20, "R11 edge entry 0");
    expect_vec(8'h21, "R11 edge entry 1");
    expect_vec(8'h41, "R11 edge entry 2");
    out_ready = 1'b1;
    wait_cycles(6);
    drained("R11 three edges delivered once each");
    chk(out_valid === 1'b0, "R11 nothing left pending", {31'd0, out_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule